// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

This block chooses which of ten interrupt request lines a processor core should service next, and when. Each request line owns one vector slot. Its priority is set by a one-bit level select. The first two slots can be made either top level or low level. The other eight can be made either middle level or low level. Each cycle, the arbiter picks the best eligible request. It accepts that request only when its level is strictly above the level now being serviced. On acceptance it raises a one-cycle take pulse, presents the slot's vector address and raises the current level.

Active levels are kept as a three-entry nesting record, with one entry per level. A return strobe from the core removes the most recent level and restores the one beneath it. With nothing active, the base level sits below low, so any enabled request can be accepted. A slot that has been taken stays locked out of arbitration until its source drops the request for at least one cycle. This stops a held request from being taken twice after the return.

Top module: `irq_vec_arbiter`

## Requirements
- R1: While reset is asserted and immediately after it is released, `take` is 0, `cur_lvl` is 0 (base) and `vec_addr` is 0.
- R2: Levels are encoded as 0 = base (none), 1 = low, 2 = middle, 3 = top. For slot i, a `lvl_sel[i]` of 0 gives low. A `lvl_sel[i]` of 1 gives top for slots 0 and 1, and middle for slots 2 to 9.
- R3: The vector address of slot i is 0x03 + 8*i, giving 0x03 for slot 0 through 0x4B for slot 9.
- R4: Among the eligible requests, one at a higher level is taken before any at a lower level.
- R5: Among eligible requests at the same level, the slot with the smallest index is taken.
- R6: A request is taken only if its level is strictly above `cur_lvl`. `take` is high for exactly the one cycle after the clock edge at which the request was sampled.
- R7: In the cycle `take` is high, `cur_lvl` already shows the level of the taken slot. Lower active levels are kept beneath it.
- R8: A `reti` pulse sampled at a clock edge removes the highest active level, and `cur_lvl` falls to the next active level or to base. A `reti` pulse at base has no effect.
- R9: No request is taken at a clock edge where `reti` is sampled high. A request that qualifies is taken at the following edge instead.
- R10: While `arb_en` is 0, nothing is taken and `cur_lvl` keeps its value. A waiting request is taken once `arb_en` returns to 1.
- R11: A slot that has been taken is not taken again until its request has been sampled low at least once.
- R12: `vec_addr` keeps the address of the last taken slot until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 10 | Request line per vector slot |
| lvl_sel | input | 10 | Per-slot level select (0 low, 1 raised) |
| arb_en | input | 1 | Global acceptance enable |
| reti | input | 1 | Return-from-interrupt strobe, one cycle |
| take | output | 1 | One-cycle acceptance pulse |
| vec_addr | output | 8 | Vector address of the last taken slot |
| cur_lvl | output | 2 | Level currently being serviced (0 base) |

## Verification
The embedded assertions cover the per-cycle rules:
- each take strictly raises the level;
- a return never coincides with a take and always lowers a non-base level;
- the vector address has the slot spacing and stays still between takes;
- a disabled arbiter takes nothing;
- the first two slots never decode to the middle level.

Other behaviours only show up across the bench's scenarios, which check them against a queue of expected takes. These are:
- which of several simultaneous requests wins, by level and by index;
- the exact level restored after nested returns;
- the lockout of a held request until it drops;
- a deferred take after a return.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_MID  = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int N_LEVELS = 3;
endpackage

// File: rtl/irq_slot_level.sv
module irq_slot_level
  import irq_arb_pkg::*;
#(
  parameter int NSLOT = 10,
  parameter int NTOP  = 2
) (
  input  logic [NSLOT-1:0] lvl_sel,
  output lvl_t             slot_lvl [NSLOT]
);
  // Slots below NTOP choose between top and low; the rest between middle and low.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NTOP) begin : g_top
      assign slot_lvl[g] = lvl_sel[g] ? LVL_TOP : LVL_LO;
    end else begin : g_mid
      assign slot_lvl[g] = lvl_sel[g] ? LVL_MID : LVL_LO;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NSLOT = 10,
  localparam int IDXW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] elig,
  input  lvl_t             slot_lvl [NSLOT],
  output logic             win_valid,
  output logic [IDXW-1:0]  win_idx,
  output lvl_t             win_lvl
);
  // Descending scan with >= : the highest level wins, and ties go to the lowest index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LVL_NONE;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (elig[i] && (slot_lvl[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_lvl   = slot_lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cur_lvl
);
  // One flag per level. Nesting only ever goes upward, so the highest set flag is the top entry.
  logic [N_LEVELS-1:0] act_q, act_d;

  always_comb begin
    cur_lvl = LVL_NONE;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (act_q[l]) cur_lvl = lvl_t'(l + 1);
    end
  end

  always_comb begin
    act_d = act_q;
    if (pop && (cur_lvl != LVL_NONE)) begin
      act_d[cur_lvl - 2'd1] = 1'b0;
    end else if (push && (push_lvl != LVL_NONE)) begin
      act_d[push_lvl - 2'd1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  // R9: the arbiter never asks for a push and a pop together
  a_r9_no_push_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  // R8: a return from a non-base level lowers the level
  a_r8_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (cur_lvl != LVL_NONE)) |=> (cur_lvl < $past(cur_lvl)));
  // R8: a return at base leaves the level at base
  a_r8_pop_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (cur_lvl == LVL_NONE)) |=> (cur_lvl == LVL_NONE));
  // R7: a push makes the pushed level current
  a_r7_push_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cur_lvl == $past(push_lvl)));
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSLOT    = 10,
  parameter int NTOP     = 2,
  parameter int AW       = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDXW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] irq_req,
  input  logic [NSLOT-1:0] lvl_sel,
  input  logic             arb_en,
  input  logic             reti,
  output logic             take,
  output logic [AW-1:0]    vec_addr,
  output logic [1:0]       cur_lvl
);
  lvl_t             slot_lvl [NSLOT];
  lvl_t             lvl_now;
  logic [NSLOT-1:0] blk_q, blk_d;
  logic [NSLOT-1:0] elig;
  logic             win_valid;
  logic [IDXW-1:0]  win_idx;
  lvl_t             win_lvl;
  logic             take_d, take_q;
  logic [AW-1:0]    vec_d, vec_q;

  irq_slot_level #(.NSLOT(NSLOT), .NTOP(NTOP)) u_lvl (
    .lvl_sel  (lvl_sel),
    .slot_lvl (slot_lvl)
  );

  assign elig = irq_req & ~blk_q;

  irq_pick #(.NSLOT(NSLOT)) u_pick (
    .elig      (elig),
    .slot_lvl  (slot_lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  irq_level_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take_d),
    .push_lvl (win_lvl),
    .pop      (reti),
    .cur_lvl  (lvl_now)
  );

  // Next-state logic
  always_comb begin
    take_d = arb_en && !reti && win_valid && (win_lvl > lvl_now);
    vec_d  = vec_q;
    if (take_d) vec_d = AW'(VEC_BASE) + AW'(win_idx) * AW'(VEC_STEP);
    // a lockout clears once the request is seen low; a take sets one
    blk_d = blk_q & irq_req;
    if (take_d) blk_d[win_idx] = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      blk_q  <= '0;
    end else begin
      take_q <= take_d;
      vec_q  <= vec_d;
      blk_q  <= blk_d;
    end
  end

  assign take     = take_q;
  assign vec_addr = vec_q;
  assign cur_lvl  = lvl_now;

  // R6: every take strictly raises the serviced level
  a_r6_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cur_lvl > $past(cur_lvl)));
  // R9: nothing is taken at an edge where a return was sampled
  a_r9_no_take_on_reti: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(reti));
  // R10: a disabled arbiter takes nothing and holds its level
  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_en && !reti) |=> (!take && $stable(cur_lvl)));
  // R3: a taken address has the slot spacing and lies in range
  a_r3_vec_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((((vec_addr - AW'(VEC_BASE)) % AW'(VEC_STEP)) == '0) &&
              (vec_addr <= AW'(VEC_BASE + VEC_STEP * (NSLOT - 1)))));
  // R12: the address moves only on a take
  a_r12_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec_addr));

  // R2: the first slots never decode to middle, the rest never to top
  for (genvar g = 0; g < NSLOT; g++) begin : g_lvl_chk
    if (g < NTOP) begin : g_t
      a_r2_no_mid_level: assert property (@(posedge clk) disable iff (!rst_n)
        slot_lvl[g] != LVL_MID);
    end else begin : g_m
      a_r2_no_top_level: assert property (@(posedge clk) disable iff (!rst_n)
        slot_lvl[g] != LVL_TOP);
    end
  end
endmodule

// File: tb/irq_vec_arbiter_test.sv
module irq_vec_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] irq_req;
  logic [9:0] lvl_sel;
  logic       arb_en;
  logic       reti;
  logic       take;
  logic [7:0] vec_addr;
  logic [1:0] cur_lvl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int    vec;
    int    lvl;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  always #10 clk = ~clk;

  irq_vec_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .lvl_sel(lvl_sel),
    .arb_en(arb_en), .reti(reti), .take(take), .vec_addr(vec_addr),
    .cur_lvl(cur_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_take(input int slot, input int lvl, input string tag);
    exp_t x;
    x.vec = 3 + 8 * slot;
    x.lvl = lvl;
    x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
  endtask

  task automatic chk_lvl(input int lvl, input string tag);
    chk(cur_lvl == 2'(lvl), tag, int'(cur_lvl), lvl);
  endtask

  task automatic chk_drained(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: pops one expected take per observed take, sampled 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1 && take === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected take", int'(vec_addr), 0);
      end else begin
        e = exp_q.pop_front();
        chk(vec_addr == 8'(e.vec), {e.tag, " vector"}, int'(vec_addr), e.vec);
        chk(cur_lvl == 2'(e.lvl), {e.tag, " level"}, int'(cur_lvl), e.lvl);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; lvl_sel = '0; arb_en = 1'b1; reti = 1'b0;
    tick(3);
    chk(take == 1'b0, "R1 take", int'(take), 0);
    chk_lvl(0, "R1 level");
    chk(vec_addr == 8'h00, "R1 vector", int'(vec_addr), 0);
    rst_n = 1'b1;
    tick(1);
    chk(take == 1'b0, "R1 take after release", int'(take), 0);

    // single low request on slot 4
    irq_req[4] = 1'b1; expect_take(4, 1, "R3");
    tick(2);
    chk_drained("R6 low take");
    chk_lvl(1, "R7 low active");

    // equal level refused
    irq_req[2] = 1'b1;
    tick(3);
    chk_drained("R6 equal refused");
    chk_lvl(1, "R6 level kept");

    // nest middle then top
    lvl_sel[7] = 1'b1; irq_req[7] = 1'b1; expect_take(7, 2, "R4 nest mid");
    tick(2);
    chk_lvl(2, "R7 mid over low");
    lvl_sel[1] = 1'b1; irq_req[1] = 1'b1; expect_take(1, 3, "R2 top slot");
    tick(2);
    chk_lvl(3, "R7 top over mid");
    chk(vec_addr == 8'h0B, "R12 vector", int'(vec_addr), 8'h0B);

    // unwind
    irq_req = '0;
    tick(1);
    pulse_reti(); chk_lvl(2, "R8 back to mid");
    pulse_reti(); chk_lvl(1, "R8 back to low");
    pulse_reti(); chk_lvl(0, "R8 back to base");
    pulse_reti(); chk_lvl(0, "R8 reti at base");
    chk(vec_addr == 8'h0B, "R12 vector held", int'(vec_addr), 8'h0B);
    chk_drained("R8 no takes during unwind");

    // simultaneous requests: 3 and 5 middle, 9 low
    lvl_sel = 10'b0000101000;
    irq_req = 10'b1000101000;
    expect_take(3, 2, "R5 lowest index");
    tick(3);
    chk_lvl(2, "R4 mid first");
    expect_take(5, 2, "R9 deferred");
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
    chk(take == 1'b0, "R9 no take on reti", int'(take), 0);
    chk_lvl(0, "R9 popped");
    tick(2);
    chk_lvl(2, "R11 next mid slot");
    expect_take(9, 1, "R4 low after mid");
    pulse_reti();
    tick(2);
    chk_lvl(1, "R4 low level");
    pulse_reti();
    tick(3);
    chk_lvl(0, "R11 held slots locked");
    chk_drained("R11 no retake");

    // drop and re-raise slot 3
    irq_req[3] = 1'b0;
    tick(1);
    irq_req[3] = 1'b1; expect_take(3, 2, "R11 retake");
    tick(2);
    chk_lvl(2, "R11 retaken level");
    irq_req = '0;
    tick(1);
    pulse_reti();
    tick(1);
    chk_lvl(0, "R8 cleared");

    // top slot 0 against middle slot 2
    lvl_sel = 10'b0000000101;
    irq_req = 10'b0000000101;
    expect_take(0, 3, "R2 slot0 top");
    tick(2);
    chk_lvl(3, "R4 top wins");
    expect_take(2, 2, "R8 mid after top");
    irq_req[0] = 1'b0;
    pulse_reti();
    tick(2);
    chk_lvl(2, "R8 mid taken");
    irq_req = '0;
    pulse_reti();
    tick(1);
    chk_lvl(0, "R8 base again");

    // low slot 0 against middle slot 8
    lvl_sel = 10'b0100000000;
    irq_req = 10'b0100000001;
    expect_take(8, 2, "R4 mid beats low");
    tick(3);
    chk_lvl(2, "R2 slot0 low");
    irq_req = '0;
    pulse_reti();
    tick(2);
    chk_lvl(0, "R8 base");
    chk_drained("R4 done");

    // enable gating
    arb_en = 1'b0;
    irq_req[6] = 1'b1;
    tick(3);
    chk_lvl(0, "R10 held while disabled");
    chk_drained("R10 no take");
    arb_en = 1'b1; expect_take(6, 1, "R10 enabled take");
    tick(2);
    chk_lvl(1, "R10 level");
    irq_req = '0;
    pulse_reti();
    tick(3);
    chk_drained("R6 final");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule